// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-side command engine of a 765-style floppy disk controller. The host writes a command byte and its parameter bytes one at a time. The block decodes the opcode in the low five bits of the first byte. It strips any flag bits that the opcode does not define and collects exactly the number of parameter bytes that opcode needs. It then holds an execution request to a drive engine until the engine signals completion. After that it returns the engine's status and sector-ID bytes to the host in a fixed order.

Both byte streams use valid/ready. A write byte is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only in the command and parameter phases. A result byte is consumed on a rising edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value. Alongside the streams the block drives three plain status bits: request-for-master, data direction and busy.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the block is idle: rqm=1, dio=0, busy=0, wr_ready=1, rd_valid=0 and exec_req=0.
- R2: Opcodes 00110 (read data), 01100 (read deleted), 00101 (write data), 01001 (write deleted) and 00010 (read track) each take eight parameter bytes. The request exec_req rises only after the eighth byte is accepted, and exec_cmd then shows the opcode.
- R3: Opcode 01010 (read ID) takes exactly one parameter byte, the drive/head byte.
- R4: Opcode 01101 (format track) takes exactly five parameter bytes, and exec_req stays low until the fifth is accepted.
- R5: Parameter bytes reach the engine in arrival order. Parameter k (0-based, where k=0 is the drive/head byte laid out as five zeros, HDS, DS1, DS0) sits in exec_params[8k+7:8k].
- R6: The first byte's bits 7,6,5 are the MT, MFM and SK flags, presented as exec_flags[2:0] = {MT,MFM,SK}. MT survives only for the read/write data and deleted-data opcodes. SK survives only for read data, read deleted and read track. MFM survives for every known opcode. Each undefined flag reads as 0.
- R7: During execution rqm=0, busy=1, wr_ready=0 and rd_valid=0, and exec_req stays high until eng_done is sampled.
- R8: A cycle where eng_done is sampled high moves the block to the result phase with dio=1 and rqm=1. Seven bytes are returned in this order: eng_st0, eng_st1, eng_st2, eng_id[31:24] (C), eng_id[23:16] (H), eng_id[15:8] (R), eng_id[7:0] (N).
- R9: An unknown opcode never raises exec_req. In the cycle after it is accepted, the block is in the result phase with a single byte of value 0x80.
- R10: When the last result byte is consumed, the block returns to idle with busy=0, dio=0 and wr_ready=1.
- R11: A cycle with soft_rst high forces the idle state from any phase. Partly collected parameters are discarded, and exec_req drops.
- R12: A result byte that is offered but not taken stays stable on rd_data. Write bytes offered while wr_ready is low are ignored and do not disturb the results that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| wr_valid | input | 1 | Host offers a command/parameter byte |
| wr_ready | output | 1 | Block accepts write bytes |
| wr_data | input | 8 | Command or parameter byte |
| rd_valid | output | 1 | A result byte is offered |
| rd_ready | input | 1 | Host takes the result byte |
| rd_data | output | 8 | Current result byte |
| rqm | output | 1 | Request for master: a byte may move |
| dio | output | 1 | Direction: 0 host writes, 1 host reads |
| busy | output | 1 | A command is in progress |
| exec_req | output | 1 | Execution request to the drive engine |
| exec_cmd | output | 5 | Opcode being executed |
| exec_flags | output | 3 | Masked {MT,MFM,SK} |
| exec_params | output | 64 | Collected parameter bytes |
| eng_done | input | 1 | Engine finished the operation |
| eng_st0 | input | 8 | Status byte 0 from the engine |
| eng_st1 | input | 8 | Status byte 1 from the engine |
| eng_st2 | input | 8 | Status byte 2 from the engine |
| eng_id | input | 32 | Sector ID from the engine: C,H,R,N from the top byte down |

## Verification
Every phase change occurs on the rising edge that accepts a byte or samples eng_done, and there are no further pipeline stages. exec_req, rd_valid and the first result byte are therefore visible one edge after the triggering handshake. The bench drives and samples on falling edges. Each write or read task spans exactly one rising edge, so every check lands in the first half-cycle after the edge that should have produced the result. To pin each change to a single edge, the bench also checks before that edge, for example exec_req low before the last parameter byte.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_PARAM, PH_EXEC, PH_RES} phase_e;

  localparam logic [4:0] OP_RD_DATA  = 5'b00110;
  localparam logic [4:0] OP_RD_DEL   = 5'b01100;
  localparam logic [4:0] OP_WR_DATA  = 5'b00101;
  localparam logic [4:0] OP_WR_DEL   = 5'b01001;
  localparam logic [4:0] OP_RD_TRACK = 5'b00010;
  localparam logic [4:0] OP_RD_ID    = 5'b01010;
  localparam logic [4:0] OP_FORMAT   = 5'b01101;

  localparam logic [7:0] ST0_BAD_CMD = 8'h80;
endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
  import fdc_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [4:0]       opcode,
  output logic             known,
  output logic [CNT_W-1:0] n_params,
  output logic [2:0]       flag_mask
);
  always_comb begin
    known     = 1'b1;
    n_params  = CNT_W'(8);
    flag_mask = 3'b010;
    case (opcode)
      OP_RD_DATA, OP_RD_DEL: flag_mask = 3'b111;
      OP_WR_DATA, OP_WR_DEL: flag_mask = 3'b110;
      OP_RD_TRACK:           flag_mask = 3'b011;
      OP_RD_ID:              n_params  = CNT_W'(1);
      OP_FORMAT:             n_params  = CNT_W'(5);
      default: begin
        known     = 1'b0;
        n_params  = '0;
        flag_mask = 3'b000;
      end
    endcase
  end
endmodule

// File: rtl/fdc_param_store.sv
module fdc_param_store #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  localparam int CNT_W     = $clog2(MAX_PARAMS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         wr_en,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [CNT_W-1:0]             count,
  output logic [MAX_PARAMS*DATA_W-1:0] params
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    count <= '0;
    else if (clear)                                count <= '0;
    else if (wr_en && count < CNT_W'(MAX_PARAMS))  count <= count + CNT_W'(1);
  end

  for (genvar k = 0; k < MAX_PARAMS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            params[k*DATA_W +: DATA_W] <= '0;
      else if (clear)                        params[k*DATA_W +: DATA_W] <= '0;
      else if (wr_en && count == CNT_W'(k))  params[k*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/fdc_result_queue.sv
module fdc_result_queue
  import fdc_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RES_BYTES = 7,
  localparam int IDX_W    = $clog2(RES_BYTES),
  localparam int LEN_W    = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        load_full,
  input  logic                        load_bad,
  input  logic [RES_BYTES*DATA_W-1:0] full_bytes,
  input  logic                        pop,
  output logic [DATA_W-1:0]           head,
  output logic                        last
);
  logic [DATA_W-1:0] slot [RES_BYTES];
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  len;

  for (genvar k = 0; k < RES_BYTES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 slot[k] <= '0;
      else if (load_full)         slot[k] <= full_bytes[k*DATA_W +: DATA_W];
      else if (load_bad && k == 0) slot[k] <= DATA_W'(ST0_BAD_CMD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      len <= '0;
    end else if (clear) begin
      idx <= '0;
    end else if (load_full) begin
      idx <= '0;
      len <= LEN_W'(RES_BYTES);
    end else if (load_bad) begin
      idx <= '0;
      len <= LEN_W'(1);
    end else if (pop && !last) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign head = slot[idx];
  assign last = (LEN_W'(idx) + LEN_W'(1)) >= len;
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  parameter int RES_BYTES  = 7,
  localparam int CNT_W     = $clog2(MAX_PARAMS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rqm,
  output logic                         dio,
  output logic                         busy,
  output logic                         exec_req,
  output logic [4:0]                   exec_cmd,
  output logic [2:0]                   exec_flags,
  output logic [MAX_PARAMS*DATA_W-1:0] exec_params,
  input  logic                         eng_done,
  input  logic [DATA_W-1:0]            eng_st0,
  input  logic [DATA_W-1:0]            eng_st1,
  input  logic [DATA_W-1:0]            eng_st2,
  input  logic [4*DATA_W-1:0]          eng_id
);
  phase_e           phase_q;
  logic [CNT_W-1:0] need_q;
  logic             known;
  logic [CNT_W-1:0] dec_n;
  logic [2:0]       dec_mask;
  logic [CNT_W-1:0] got;
  logic             q_last;

  logic wr_fire, rd_fire, first_fire, param_fire, last_param, finish;
  logic [RES_BYTES*DATA_W-1:0] res_flat;

  assign wr_ready   = (phase_q == PH_CMD) || (phase_q == PH_PARAM);
  assign rd_valid   = (phase_q == PH_RES);
  assign wr_fire    = wr_valid && wr_ready;
  assign rd_fire    = rd_valid && rd_ready;
  assign first_fire = wr_fire && phase_q == PH_CMD;
  assign param_fire = wr_fire && phase_q == PH_PARAM;
  assign last_param = param_fire && (got == need_q - CNT_W'(1));
  assign finish     = phase_q == PH_EXEC && eng_done;

  assign rqm      = wr_ready || rd_valid;
  assign dio      = rd_valid;
  assign busy     = phase_q != PH_CMD;
  assign exec_req = phase_q == PH_EXEC;

  fdc_op_decode #(.CNT_W(CNT_W)) u_dec (
    .opcode    (wr_data[4:0]),
    .known     (known),
    .n_params  (dec_n),
    .flag_mask (dec_mask)
  );

  fdc_param_store #(.DATA_W(DATA_W), .MAX_PARAMS(MAX_PARAMS)) u_params (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (soft_rst || first_fire),
    .wr_en   (param_fire && !soft_rst),
    .wr_data (wr_data),
    .count   (got),
    .params  (exec_params)
  );

  assign res_flat = {eng_id[DATA_W-1:0], eng_id[2*DATA_W-1:DATA_W],
                     eng_id[3*DATA_W-1:2*DATA_W], eng_id[4*DATA_W-1:3*DATA_W],
                     eng_st2, eng_st1, eng_st0};

  fdc_result_queue #(.DATA_W(DATA_W), .RES_BYTES(RES_BYTES)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (soft_rst),
    .load_full  (finish && !soft_rst),
    .load_bad   (first_fire && !known && !soft_rst),
    .full_bytes (res_flat),
    .pop        (rd_fire),
    .head       (rd_data),
    .last       (q_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_CMD;
      need_q     <= '0;
      exec_cmd   <= '0;
      exec_flags <= '0;
    end else if (soft_rst) begin
      phase_q <= PH_CMD;
    end else begin
      case (phase_q)
        PH_CMD: if (first_fire) begin
          exec_cmd   <= wr_data[4:0];
          exec_flags <= wr_data[DATA_W-1 -: 3] & dec_mask;
          need_q     <= dec_n;
          phase_q    <= known ? PH_PARAM : PH_RES;
        end
        PH_PARAM: if (last_param) phase_q <= PH_EXEC;
        PH_EXEC:  if (eng_done) phase_q <= PH_RES;
        PH_RES:   if (rd_fire && q_last) phase_q <= PH_CMD;
        default:  phase_q <= PH_CMD;
      endcase
    end
  end
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rqm,
  input logic              dio,
  input logic              busy,
  input logic              exec_req,
  input logic              eng_done
);
  p_exec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |-> (!rqm && busy && !wr_ready && !rd_valid));

  p_exec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && !eng_done && !soft_rst) |=> exec_req);

  p_read_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (dio && rqm && !wr_ready));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wr_ready && !dio && !exec_req));

  p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !busy && !soft_rst && wr_data[4:0] == 5'b00000)
      |=> (rd_valid && rd_data == 8'h80 && !exec_req));

  p_soft_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !exec_req && wr_ready));

  p_hold_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !soft_rst) |=> (rd_valid && $stable(rd_data)));
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .rqm      (rqm),
  .dio      (dio),
  .busy     (busy),
  .exec_req (exec_req),
  .eng_done (eng_done)
);

// File: tb/fdc_cmd_seq_test.sv
module fdc_cmd_seq_test;
  logic        clk = 0, rst_n = 0, soft_rst = 0;
  logic        wr_valid = 0, rd_ready = 0, eng_done = 0;
  logic [7:0]  wr_data = 0, eng_st0 = 0, eng_st1 = 0, eng_st2 = 0;
  logic [31:0] eng_id = 0;
  logic        wr_ready, rd_valid, rqm, dio, busy, exec_req;
  logic [7:0]  rd_data;
  logic [4:0]  exec_cmd;
  logic [2:0]  exec_flags;
  logic [63:0] exec_params;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fdc_cmd_seq uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    wr_valid = 1; wr_data = b;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    b = rd_data;
    chk(rd_valid === 1'b1, "R8 rd_valid", {63'b0, rd_valid}, 1);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [63:0] p, input int n);
    put_byte(op);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1)
        chk(exec_req === 1'b0, "R2 no early exec_req", {63'b0, exec_req}, 0);
      put_byte(p[i*8 +: 8]);
    end
  endtask

  task automatic finish_exec(input logic [7:0] s0, s1, s2, input logic [31:0] id);
    eng_st0 = s0; eng_st1 = s1; eng_st2 = s2; eng_id = id; eng_done = 1;
    @(negedge clk);
    eng_done = 0;
  endtask

  task automatic read_results(input logic [55:0] exp);
    logic [7:0] b;
    for (int i = 0; i < 7; i++) begin
      get_byte(b);
      chk(b === exp[i*8 +: 8], "R8 result order", b, exp[i*8 +: 8]);
    end
    chk(busy === 0 && dio === 0 && wr_ready === 1, "R10 idle after last read",
        {busy, dio, wr_ready}, 3'b001);
  endtask

  task automatic t_reset;
    chk({rqm, dio, busy, wr_ready, rd_valid, exec_req} === 6'b100100, "R1 reset state",
        {rqm, dio, busy, wr_ready, rd_valid, exec_req}, 6'b100100);
  endtask

  task automatic t_read_data;
    logic [63:0] p = 64'h0203_8712_0401_3305;
    send_cmd(8'hE6, p, 8);
    chk(exec_req === 1 && exec_cmd === 5'b00110, "R2 read data exec", {exec_req, exec_cmd}, {1'b1, 5'b00110});
    chk(exec_params === p, "R5 param order", exec_params, p);
    chk(exec_flags === 3'b111, "R6 read data flags", exec_flags, 3'b111);
    repeat (3) @(negedge clk);
    chk({rqm, busy, wr_ready, rd_valid, exec_req} === 5'b01001, "R7 exec phase",
        {rqm, busy, wr_ready, rd_valid, exec_req}, 5'b01001);
    finish_exec(8'h21, 8'h04, 8'h40, 32'h33010402);
    chk(dio === 1 && rqm === 1, "R8 result direction", {dio, rqm}, 2'b11);
    read_results({8'h02, 8'h04, 8'h01, 8'h33, 8'h40, 8'h04, 8'h21});
  endtask

  task automatic t_read_track;
    send_cmd(8'hE2, 64'h1111_2222_3333_4400, 8);
    chk(exec_req === 1 && exec_cmd === 5'b00010, "R2 read track exec", {exec_req, exec_cmd}, {1'b1, 5'b00010});
    chk(exec_flags === 3'b011, "R6 read track MT masked", exec_flags, 3'b011);
    finish_exec(8'h00, 8'h00, 8'h00, 32'h0);
    read_results(56'h0);
  endtask

  task automatic t_write_data;
    send_cmd(8'hE5, 64'hA1A2_A3A4_A5A6_A7A8, 8);
    chk(exec_cmd === 5'b00101, "R2 write data exec", exec_cmd, 5'b00101);
    chk(exec_flags === 3'b110, "R6 write data SK masked", exec_flags, 3'b110);
    finish_exec(8'h01, 8'h02, 8'h03, 32'h04050607);
    read_results({8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01});
  endtask

  task automatic t_read_id;
    send_cmd(8'hEA, 64'h05, 1);
    chk(exec_req === 1 && exec_cmd === 5'b01010, "R3 read id after one byte", {exec_req, exec_cmd}, {1'b1, 5'b01010});
    chk(exec_params[7:0] === 8'h05, "R5 drive/head byte", exec_params[7:0], 8'h05);
    chk(exec_flags === 3'b010, "R6 read id flags", exec_flags, 3'b010);
    finish_exec(8'h11, 8'h22, 8'h33, 32'h44556677);
    read_results({8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11});
  endtask

  task automatic t_format;
    send_cmd(8'hED, 64'h00E5_1B12_0201, 5);
    chk(exec_req === 1 && exec_cmd === 5'b01101, "R4 format after five bytes", {exec_req, exec_cmd}, {1'b1, 5'b01101});
    chk(exec_params[39:0] === 40'hE51B120201, "R4 format params", exec_params[39:0], 40'hE51B120201);
    chk(exec_flags === 3'b010, "R6 format flags", exec_flags, 3'b010);
    finish_exec(8'h00, 8'h00, 8'h00, 32'h0);
    read_results(56'h0);
  endtask

  task automatic t_bad_op;
    logic [7:0] b;
    put_byte(8'h1F);
    chk(exec_req === 0 && rd_valid === 1 && dio === 1, "R9 straight to result",
        {exec_req, rd_valid, dio}, 3'b011);
    get_byte(b);
    chk(b === 8'h80, "R9 invalid ST0", b, 8'h80);
    chk(busy === 0 && wr_ready === 1, "R10 idle after single byte", {busy, wr_ready}, 2'b01);
  endtask

  task automatic t_soft_reset;
    put_byte(8'h46); put_byte(8'h01); put_byte(8'h02);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk(busy === 0 && wr_ready === 1, "R11 idle from params", {busy, wr_ready}, 2'b01);
    send_cmd(8'h4A, 64'h06, 1);
    chk(exec_req === 1 && exec_params[7:0] === 8'h06, "R11 fresh count", {exec_req, exec_params[7:0]}, {1'b1, 8'h06});
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk(exec_req === 0 && busy === 0 && rd_valid === 0, "R11 idle from exec",
        {exec_req, busy, rd_valid}, 3'b000);
  endtask

  task automatic t_backpressure;
    logic [7:0] first;
    send_cmd(8'h4A, 64'h01, 1);
    finish_exec(8'hC1, 8'hC2, 8'hC3, 32'hC4C5C6C7);
    first = rd_data;
    wr_valid = 1; wr_data = 8'hAA;
    repeat (3) @(negedge clk);
    chk(wr_ready === 0, "R12 no write in result phase", wr_ready, 0);
    wr_valid = 0;
    chk(rd_data === first && rd_data === 8'hC1, "R12 held result", rd_data, 8'hC1);
    read_results({8'hC7, 8'hC6, 8'hC5, 8'hC4, 8'hC3, 8'hC2, 8'hC1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_data();
    t_read_track();
    t_write_data();
    t_read_id();
    t_format();
    t_bad_op();
    t_soft_reset();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule